// File: doc/BRIEF.md
# Sequenced Third-Order Sinc Decimator

This block turns a single-bit oversampled modulator stream into multi-bit conversion words with a third-order sinc (cascaded integrator-comb) filter. The decimation ratio R can be set, and it fixes the word rate and so the first notch. A large R gives a low notch and deep rejection of an FSK carrier riding on a current loop. A small R gives a fast conversion when rejection is not needed.

One filter serves up to `NUM_CH` analog inputs, taken one at a time. For each enabled input the sequencer drives the external multiplexer select, clears every filter register and latches the ratio. It lets the filter run for three output periods. It then publishes the third word with the channel number and a one-cycle valid strobe, and moves to the next enabled input. A full scan therefore lasts (number of enabled channels) × (3R+1) clock cycles.

Top module: `sinc3_scan`

## Requirements
- R1: While reset is held and afterwards while `chanEnable` is zero, `resValid` is 0 and `muxSel`, `resData` and `resChan` are 0.
- R2: A conversion whose input bits are all ones returns R³. One whose bits are all zeros returns 0. `resData` is unsigned and right-justified.
- R3: If every run of R consecutive input bits holds k ones (a pattern periodic with a period dividing R), the result is k·R². Both a 1-in-2 pattern and a 1-in-4 pattern follow this rule.
- R4: A channel switch happens at the first clock edge where it is due. `resValid` rises 3R+1 edges later and stays high for one cycle. Consecutive results in a running scan are 3R+1 cycles apart, and the first two decimated words of a conversion are never published.
- R5: Channels are visited in ascending index order. Channels whose `chanEnable` bit is 0 are skipped, and the order wraps from the highest enabled channel to the lowest. A scan started from idle begins with the lowest enabled channel.
- R6: `muxSel` holds the channel under conversion for the whole conversion, and `resChan` of each result equals that channel.
- R7: `cfgRatio` is sampled only at a channel switch. A change made during a conversion takes effect at the following conversion.
- R8: All filter state is cleared at each switch, so a result depends only on bits taken after that switch. For example, an all-zero channel that follows an all-one channel returns exactly 0.
- R9: When `chanEnable` becomes zero, the conversion in progress completes and publishes. After that no result appears and `muxSel` holds its value.
- R10: At the largest ratio, R = 2^RATIO_W, an all-ones conversion returns 2^(3·RATIO_W) without wraparound.
- R11: `cfgRatio` carries R−1. A value of 0 gives R = 1, the fastest mode, where each result equals the single input bit (1 or 0), four cycles per channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator bit clock; one input bit per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| modBit | input | 1 | Modulator output bit for the selected channel |
| cfgRatio | input | RATIO_W | Decimation ratio minus one |
| chanEnable | input | NUM_CH | One enable bit per input channel |
| muxSel | output | max(1,log2 NUM_CH) | External multiplexer select |
| resData | output | 1+3·RATIO_W | Settled conversion result |
| resChan | output | max(1,log2 NUM_CH) | Channel tag of the result |
| resValid | output | 1 | One-cycle strobe marking a new result |

## Verification
Each channel's modulator model feeds a fixed pattern: all ones, all zeros, alternating bits, and one-in-four. Full-scale and zero results show the gain and the unsigned mapping. The two fractional densities show the k·R² law and would expose a wrong stage delay or a partly filled window. The sweep covers ratios from 1 to the maximum, because the result interval and the first-result latency separate a correct three-word settle from a design that publishes early. Sparse and single-channel masks, a mid-conversion ratio change and a mask dropped to zero exercise the ordering, latching and drain rules.

// File: rtl/sinc3_scan_pkg.sv
package sinc3_scan_pkg;

  // filter order: integrator and comb stage count
  localparam int ORDER = 3;

  // strobes sent from the sequencer to the datapath
  typedef struct packed {
    logic clearAll;    // wipe integrators and comb delays (channel switch)
    logic accumulate;  // integrators take one modulator bit
    logic combStep;    // comb takes the current integrator output
    logic publish;     // present the comb output as a result
  } seq_strobe_t;

endpackage

// File: rtl/sinc3_scan_ctrl.sv
module sinc3_scan_ctrl
  import sinc3_scan_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int RATIO_W = 8,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] cfgRatio,
  input  logic [NUM_CH-1:0]  chanEnable,
  output logic [CH_W-1:0]    curChan,
  output seq_strobe_t        strb
);

  localparam int WC_W = $clog2(ORDER + 1);

  logic               active;
  logic [CH_W-1:0]    cur;
  logic [RATIO_W-1:0] ratioLat;
  logic [RATIO_W-1:0] sampCnt;
  logic               combPend;
  logic [WC_W-1:0]    wordCnt;

  logic            anyEn;
  logic            lastWord;
  logic            ratioHit;
  logic            doSwitch;
  logic            goIdle;
  logic [CH_W-1:0] nextChan;
  logic [CH_W-1:0] lowAny;
  logic [CH_W-1:0] lowAbove;
  logic            foundAbove;

  assign anyEn    = |chanEnable;
  assign lastWord = combPend && (wordCnt == WC_W'(ORDER - 1));
  assign ratioHit = (sampCnt == ratioLat);
  assign doSwitch = anyEn && (!active || lastWord);
  assign goIdle   = active && lastWord && !anyEn;

  // next channel: lowest enabled above the current one, else lowest enabled
  always_comb begin
    lowAny     = '0;
    lowAbove   = '0;
    foundAbove = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (chanEnable[i]) begin
        lowAny = CH_W'(i);
        if (active && (i > int'(cur))) begin
          lowAbove   = CH_W'(i);
          foundAbove = 1'b1;
        end
      end
    end
    nextChan = foundAbove ? lowAbove : lowAny;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      cur      <= '0;
      ratioLat <= '0;
      sampCnt  <= '0;
      combPend <= 1'b0;
      wordCnt  <= '0;
    end else if (doSwitch) begin
      active   <= 1'b1;
      cur      <= nextChan;
      ratioLat <= cfgRatio;
      sampCnt  <= '0;
      combPend <= 1'b0;
      wordCnt  <= '0;
    end else if (goIdle) begin
      active   <= 1'b0;
      combPend <= 1'b0;
    end else if (active) begin
      sampCnt  <= ratioHit ? '0 : sampCnt + RATIO_W'(1);
      combPend <= ratioHit;
      if (combPend) wordCnt <= wordCnt + WC_W'(1);
    end
  end

  assign curChan         = cur;
  assign strb.clearAll   = doSwitch;
  assign strb.accumulate = active;
  assign strb.combStep   = combPend;
  assign strb.publish    = lastWord;

endmodule

// File: rtl/sinc3_scan_dpath.sv
module sinc3_scan_dpath
  import sinc3_scan_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int RATIO_W = 8,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int DW     = 1 + ORDER * RATIO_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            modBit,
  input  seq_strobe_t     strb,
  input  logic [CH_W-1:0] curChan,
  output logic [DW-1:0]   resData,
  output logic [CH_W-1:0] resChan,
  output logic            resValid
);

  logic [DW-1:0] integOut [ORDER];
  logic [DW-1:0] diff     [ORDER+1];

  // integrator chain at the modulator rate (modular arithmetic)
  for (genvar g = 0; g < ORDER; g++) begin : g_integ
    logic [DW-1:0] stageIn;
    logic [DW-1:0] accReg;
    if (g == 0) begin : g_first
      assign stageIn = {{(DW-1){1'b0}}, modBit};
    end else begin : g_next
      assign stageIn = integOut[g-1];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                accReg <= '0;
      else if (strb.clearAll)   accReg <= '0;
      else if (strb.accumulate) accReg <= accReg + stageIn;
    end
    assign integOut[g] = accReg;
  end

  // comb chain at the decimated rate
  assign diff[0] = integOut[ORDER-1];
  for (genvar g = 0; g < ORDER; g++) begin : g_comb
    logic [DW-1:0] dlyReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              dlyReg <= '0;
      else if (strb.clearAll) dlyReg <= '0;
      else if (strb.combStep) dlyReg <= diff[g];
    end
    assign diff[g+1] = diff[g] - dlyReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resData  <= '0;
      resChan  <= '0;
    end else begin
      resValid <= strb.publish;
      if (strb.publish) begin
        resData <= diff[ORDER];
        resChan <= curChan;
      end
    end
  end

endmodule

// File: rtl/sinc3_scan.sv
module sinc3_scan
  import sinc3_scan_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int RATIO_W = 8,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int DW     = 1 + ORDER * RATIO_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modBit,
  input  logic [RATIO_W-1:0] cfgRatio,
  input  logic [NUM_CH-1:0]  chanEnable,
  output logic [CH_W-1:0]    muxSel,
  output logic [DW-1:0]      resData,
  output logic [CH_W-1:0]    resChan,
  output logic               resValid
);

  seq_strobe_t strb;

  sinc3_scan_ctrl #(.NUM_CH(NUM_CH), .RATIO_W(RATIO_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgRatio   (cfgRatio),
    .chanEnable (chanEnable),
    .curChan    (muxSel),
    .strb       (strb)
  );

  sinc3_scan_dpath #(.NUM_CH(NUM_CH), .RATIO_W(RATIO_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .modBit   (modBit),
    .strb     (strb),
    .curChan  (muxSel),
    .resData  (resData),
    .resChan  (resChan),
    .resValid (resValid)
  );

endmodule

// File: rtl/sinc3_scan_chk.sv
module sinc3_scan_chk
  import sinc3_scan_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int RATIO_W = 8,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int DW     = 1 + ORDER * RATIO_W
) (
  input logic            clk,
  input logic            rstN,
  input logic [CH_W-1:0] muxSel,
  input logic [DW-1:0]   resData,
  input logic [CH_W-1:0] resChan,
  input logic            resValid,
  input logic            clearAll
);

  localparam logic [DW-1:0] FULL = DW'(1) << (ORDER * RATIO_W);

  // R4: a result strobe lasts a single cycle
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  // R6: tag equals the select that was driven during the conversion
  p_tag_matches_r6: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resChan == $past(muxSel)));

  // R2 / R10: the result never exceeds full scale R^3
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resData <= FULL));

  // R5: the select only moves at a channel switch
  p_mux_moves_on_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(muxSel) |-> $past(clearAll));

endmodule

bind sinc3_scan sinc3_scan_chk #(.NUM_CH(NUM_CH), .RATIO_W(RATIO_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .muxSel   (muxSel),
  .resData  (resData),
  .resChan  (resChan),
  .resValid (resValid),
  .clearAll (strb.clearAll)
);

// File: tb/sim_sinc3_scan.sv
`timescale 1ns/1ps
module sim_sinc3_scan;

  localparam int NCH = 4;
  localparam int RW  = 8;
  localparam int CW  = 2;
  localparam int DW  = 1 + 3 * RW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          modBit = 1'b0;
  logic [RW-1:0] cfgRatio = '0;
  logic [NCH-1:0] chanEnable = '0;
  logic [CW-1:0] muxSel;
  logic [DW-1:0] resData;
  logic [CW-1:0] resChan;
  logic          resValid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int benchR = 4;
  int ph     = 0;
  bit done   = 1'b0;

  sinc3_scan #(.NUM_CH(NCH), .RATIO_W(RW)) u0 (
    .clk(clk), .rstN(rstN), .modBit(modBit), .cfgRatio(cfgRatio),
    .chanEnable(chanEnable), .muxSel(muxSel), .resData(resData),
    .resChan(resChan), .resValid(resValid)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // modulator model: pattern chosen by the selected channel
  initial begin
    forever begin
      @(negedge clk);
      ph = ph + 1;
      case (muxSel)
        2'd0: modBit = 1'b1;
        2'd1: modBit = 1'b0;
        2'd2: modBit = (benchR % 2 == 0) ? ph[0] : 1'b1;
        default: modBit = (benchR % 4 == 0) ? (ph % 4 == 0) : 1'b0;
      endcase
    end
  end

  function automatic longint expVal(int ch, int r);
    longint rr = longint'(r);
    case (ch)
      0: return rr * rr * rr;
      1: return 0;
      2: return (r % 2 == 0) ? (rr / 2) * rr * rr : rr * rr * rr;
      default: return (r % 4 == 0) ? (rr / 4) * rr * rr : 0;
    endcase
  endfunction

  function automatic int lowestEn(logic [NCH-1:0] m);
    for (int i = 0; i < NCH; i++) if (m[i]) return i;
    return 0;
  endfunction

  function automatic int nextEn(logic [NCH-1:0] m, int c);
    for (int i = c + 1; i < NCH; i++) if (m[i]) return i;
    return lowestEn(m);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // wait for a result; report data, tag, select before the strobe,
  // negedges waited and the cycle stamp
  task automatic getResult(output longint d, output int ch, output int muxPrev,
                           output int waited, output int stamp);
    int lastMux = int'(muxSel);
    waited = 0;
    forever begin
      @(negedge clk);
      waited++;
      if (resValid) break;
      lastMux = int'(muxSel);
      if (waited > 4000) break;
    end
    check(resValid == 1'b1, "R4 result timeout", waited, 0);
    d = longint'(resData);
    ch = int'(resChan);
    muxPrev = lastMux;
    stamp = cyc;
  endtask

  task automatic drain(int r, int expCh);
    longint d; int ch, mp, w, st, hold;
    chanEnable = '0;
    getResult(d, ch, mp, w, st);
    check(ch == expCh, "R9 in-flight tag", ch, expCh);
    check(d == expVal(ch, r), "R9 in-flight data", d, expVal(ch, r));
    hold = int'(muxSel);
    for (int i = 0; i < 3 * r + 8; i++) begin
      @(negedge clk);
      if (resValid) begin
        check(1'b0, "R9 result while idle", 1, 0);
        break;
      end
    end
    check(int'(muxSel) == hold, "R9 select holds", muxSel, hold);
  endtask

  task automatic runScan(int r, logic [NCH-1:0] mask, int n);
    longint d, e; int ch, mp, w, st, prevSt, expCh;
    string tag;
    benchR = r;
    cfgRatio = RW'(r - 1);
    chanEnable = mask;
    expCh = lowestEn(mask);
    prevSt = 0;
    for (int i = 0; i < n; i++) begin
      getResult(d, ch, mp, w, st);
      if (i == 0) check(w == 3 * r + 2, "R4 first latency", w, 3 * r + 2);
      else        check(st - prevSt == 3 * r + 1, "R4 result spacing", st - prevSt, 3 * r + 1);
      check(ch == expCh, "R5 channel order", ch, expCh);
      check(mp == ch, "R6 select during conversion", mp, ch);
      e = expVal(ch, r);
      if (r == 1 || r == 2) tag = "R11 fast mode data";
      else if (r == 256 && ch == 0) tag = "R10 max ratio full scale";
      else if (ch == 1 && i > 0) tag = "R8 cleared after previous channel";
      else if (ch >= 2) tag = "R3 density result";
      else tag = "R2 full scale or zero";
      check(d == e, tag, d, e);
      prevSt = st;
      expCh = nextEn(mask, ch);
    end
    drain(r, expCh);
  endtask

  task automatic ratioChange();
    longint d; int ch, mp, w, st, prevSt;
    benchR = 4;
    cfgRatio = RW'(3);
    chanEnable = 4'b0001;
    getResult(d, ch, mp, w, st);
    check(d == 64, "R7 initial ratio", d, 64);
    cfgRatio = RW'(7);
    prevSt = st;
    getResult(d, ch, mp, w, st);
    check(d == 64, "R7 change not applied mid-conversion", d, 64);
    check(st - prevSt == 13, "R7 old spacing kept", st - prevSt, 13);
    prevSt = st;
    getResult(d, ch, mp, w, st);
    check(d == 512, "R7 new ratio applied", d, 512);
    check(st - prevSt == 25, "R7 new spacing", st - prevSt, 25);
    drain(8, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(resValid == 1'b0, "R1 reset valid", resValid, 0);
    check(muxSel == '0, "R1 reset select", muxSel, 0);
    check(resData == '0 && resChan == '0, "R1 reset result", resData, 0);
    rstN = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (resValid || muxSel != '0) begin
        check(1'b0, "R1 quiet with empty mask", resValid, 0);
        break;
      end
    end
    checks++;
    runScan(4, 4'b1111, 8);
    runScan(8, 4'b1111, 8);
    runScan(16, 4'b1111, 4);
    runScan(1, 4'b1111, 8);
    runScan(2, 4'b1111, 8);
    runScan(256, 4'b1111, 4);
    runScan(4, 4'b1010, 6);
    runScan(8, 4'b0100, 3);
    runScan(4, 4'b1001, 5);
    ratioChange();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule